// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block supplies the two ALU operands of a five-stage load/store integer pipeline with 32 registers. In the execute stage it compares the two source register numbers of the instruction in flight with the destinations of the two older instructions downstream. When there is a match, it replaces the stale value read in decode with the newer result. The execute/memory result is the younger of the two and is preferred over the memory/writeback result. Register 0 is never a bypass target. The second operand is chosen between the forwarded register value and the sign-extended immediate only after forwarding, so a store still receives its forwarded data on a separate output.

The block also contains the register file. Its single write port is driven by the memory/writeback stage. Its two read ports serve decode. When a read and a write hit the same nonzero register in the same cycle, the read port returns the value being written.

Top module: `fwd_bypass_unit`

## Requirements
- R1: Each operand has a 2-bit select: 2'b10 takes the execute/memory result, 2'b01 takes the memory/writeback result, and 2'b00 takes the decode-read value. The operand output equals the chosen source, and 2'b11 never appears.
- R2: Select 2'b10 is chosen for an operand exactly when em_we is 1, em_dst is nonzero, and em_dst equals that operand's source register.
- R3: Select 2'b01 is chosen exactly when mw_we is 1, mw_dst is nonzero, mw_dst equals the source register, and the condition of R2 does not hold for that operand.
- R4: When both stages match the same source register, select 2'b10 wins. With three back-to-back writes to one register, the third instruction gets the newest result.
- R5: A source register of 0 always gets select 2'b00, even when a stage with write enable set targets register 0.
- R6: op_b is ex_imm when ex_use_imm is 1, and otherwise the forwarded second operand. store_data is always the forwarded second operand, whatever ex_use_imm is.
- R7: A write with mw_we=1 to a nonzero register updates that register at the clock edge. Register 0 always reads as zero, and a write to it has no effect.
- R8: A decode read of a nonzero register that mw_dst is writing in the same cycle (mw_we=1) returns mw_res.
- R9: After reset every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_rs_a | input | 5 | Decode read register, port A |
| dec_rs_b | input | 5 | Decode read register, port B |
| dec_val_a | output | 32 | Register file read data, port A |
| dec_val_b | output | 32 | Register file read data, port B |
| ex_src_a | input | 5 | Execute-stage first source register |
| ex_src_b | input | 5 | Execute-stage second source register |
| ex_val_a | input | 32 | First operand value read in decode |
| ex_val_b | input | 32 | Second operand value read in decode |
| ex_imm | input | 32 | Sign-extended immediate |
| ex_use_imm | input | 1 | 1 selects the immediate as second ALU operand |
| em_dst | input | 5 | Execute/memory destination register |
| em_we | input | 1 | Execute/memory register write enable |
| em_res | input | 32 | Execute/memory result |
| mw_dst | input | 5 | Memory/writeback destination register |
| mw_we | input | 1 | Memory/writeback register write enable |
| mw_res | input | 32 | Memory/writeback result, also the register file write data |
| sel_a | output | 2 | First operand select code |
| sel_b | output | 2 | Second operand select code |
| op_a | output | 32 | Forwarded first ALU operand |
| op_b | output | 32 | Second ALU operand after the immediate choice |
| store_data | output | 32 | Forwarded second operand before the immediate choice |

## Verification
The bench goes after these cases:
- Both stages target the same source register. A design with the priority reversed would hand the older memory/writeback value to the third of three chained writers.
- A stage with write enable set targets register 0. A design missing the nonzero check would forward garbage into an instruction that reads the hard-wired zero.
- A store uses the immediate. A design with the immediate mux placed before forwarding would lose the forwarded store data.
- A decode read hits the register being written in the same cycle. A design without the internal bypass would return the old contents.

Random traffic confined to a few register numbers makes hazards on both operands at once frequent.

// File: rtl/fwd_bypass_unit.sv
module fwd_bypass_unit #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dec_rs_a,
  input  logic [AW-1:0] dec_rs_b,
  output logic [DW-1:0] dec_val_a,
  output logic [DW-1:0] dec_val_b,
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic [DW-1:0] ex_val_a,
  input  logic [DW-1:0] ex_val_b,
  input  logic [DW-1:0] ex_imm,
  input  logic          ex_use_imm,
  input  logic [AW-1:0] em_dst,
  input  logic          em_we,
  input  logic [DW-1:0] em_res,
  input  logic [AW-1:0] mw_dst,
  input  logic          mw_we,
  input  logic [DW-1:0] mw_res,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  output logic [DW-1:0] store_data
);
  localparam int NREG = 1 << AW;
  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_MW = 2'b01;
  localparam logic [1:0] SEL_EM = 2'b10;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (mw_we && mw_dst != '0) begin
      regs[mw_dst] <= mw_res;
    end
  end

  assign dec_val_a = (dec_rs_a == '0) ? '0 :
                     (mw_we && mw_dst == dec_rs_a) ? mw_res : regs[dec_rs_a];
  assign dec_val_b = (dec_rs_b == '0) ? '0 :
                     (mw_we && mw_dst == dec_rs_b) ? mw_res : regs[dec_rs_b];

  wire em_live = em_we && (em_dst != '0);
  wire mw_live = mw_we && (mw_dst != '0);

  assign sel_a = (em_live && em_dst == ex_src_a) ? SEL_EM :
                 (mw_live && mw_dst == ex_src_a) ? SEL_MW : SEL_RF;
  assign sel_b = (em_live && em_dst == ex_src_b) ? SEL_EM :
                 (mw_live && mw_dst == ex_src_b) ? SEL_MW : SEL_RF;

  logic [DW-1:0] fwd_a, fwd_b;

  always_comb begin
    case (sel_a)
      SEL_EM:  fwd_a = em_res;
      SEL_MW:  fwd_a = mw_res;
      default: fwd_a = ex_val_a;
    endcase
    case (sel_b)
      SEL_EM:  fwd_b = em_res;
      SEL_MW:  fwd_b = mw_res;
      default: fwd_b = ex_val_b;
    endcase
  end

  assign op_a       = fwd_a;
  assign store_data = fwd_b;
  assign op_b       = ex_use_imm ? ex_imm : fwd_b;
endmodule

// File: rtl/fwd_bypass_unit_chk.sv
module fwd_bypass_unit_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] dec_rs_a,
  input logic [DW-1:0] dec_val_a,
  input logic [AW-1:0] ex_src_a,
  input logic [AW-1:0] ex_src_b,
  input logic [DW-1:0] ex_imm,
  input logic          ex_use_imm,
  input logic [DW-1:0] em_res,
  input logic [AW-1:0] mw_dst,
  input logic          mw_we,
  input logic [DW-1:0] mw_res,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic [DW-1:0] store_data
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0; else armed <= 1'b1;

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_a != 2'b11 && sel_b != 2'b11);  // R1
  AST_EM_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_a == 2'b10 |-> op_a == em_res);  // R2
  AST_MW_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_a == 2'b01 |-> op_a == mw_res);  // R3
  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src_a == '0 |-> sel_a == 2'b00) and (ex_src_b == '0 |-> sel_b == 2'b00));  // R5
  AST_IMM_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    ex_use_imm |-> op_b == ex_imm);  // R6
  AST_REG_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_use_imm |-> op_b == store_data);  // R6
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dec_rs_a == '0 |-> dec_val_a == '0);  // R7
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(mw_we) && $past(mw_dst) != '0 && dec_rs_a == $past(mw_dst)
      && !(mw_we && mw_dst == dec_rs_a) |-> dec_val_a == $past(mw_res));  // R7
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mw_we && mw_dst != '0 && dec_rs_a == mw_dst |-> dec_val_a == mw_res);  // R8
endmodule

bind fwd_bypass_unit fwd_bypass_unit_chk #(.DW(DW), .AW(AW)) chk_i (.*);

// File: tb/fwd_bypass_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_bypass_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  dec_rs_a, dec_rs_b, ex_src_a, ex_src_b, em_dst, mw_dst;
  logic [31:0] dec_val_a, dec_val_b, ex_val_a, ex_val_b, ex_imm, em_res, mw_res;
  logic [31:0] op_a, op_b, store_data;
  logic        ex_use_imm, em_we, mw_we;
  logic [1:0]  sel_a, sel_b;

  always #10 clk = ~clk;

  fwd_bypass_unit dut_i (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [31:0] model [32];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) if (rst_n && mw_we && mw_dst != 0) model[mw_dst] = mw_res;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(logic [4:0] src);
    if (em_we && em_dst != 0 && em_dst == src) return 2'b10;
    if (mw_we && mw_dst != 0 && mw_dst == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(logic [4:0] src);
    if (src == 0) return "R5";
    if (em_we && em_dst != 0 && em_dst == src)
      return (mw_we && mw_dst == src) ? "R4" : "R2";
    if (mw_we && mw_dst != 0 && mw_dst == src) return "R3";
    return "R1";
  endfunction

  function automatic logic [31:0] exp_fwd(logic [1:0] s, logic [31:0] rf);
    return s == 2'b10 ? em_res : s == 2'b01 ? mw_res : rf;
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a);
    if (a == 0) return 0;
    if (mw_we && mw_dst == a) return mw_res;
    return model[a];
  endfunction

  task automatic check_all();
    logic [31:0] fb;
    #2;
    chk({sel_tag(ex_src_a), " sel_a"}, 32'(sel_a), 32'(exp_sel(ex_src_a)));
    chk({sel_tag(ex_src_b), " sel_b"}, 32'(sel_b), 32'(exp_sel(ex_src_b)));
    chk("R1 op_a", op_a, exp_fwd(exp_sel(ex_src_a), ex_val_a));
    fb = exp_fwd(exp_sel(ex_src_b), ex_val_b);
    chk("R6 store_data", store_data, fb);
    chk("R6 op_b", op_b, ex_use_imm ? ex_imm : fb);
    chk((mw_we && mw_dst == dec_rs_a && dec_rs_a != 0) ? "R8 read_a" : "R7 read_a",
        dec_val_a, exp_read(dec_rs_a));
    chk((mw_we && mw_dst == dec_rs_b && dec_rs_b != 0) ? "R8 read_b" : "R7 read_b",
        dec_val_b, exp_read(dec_rs_b));
  endtask

  task automatic idle();
    {dec_rs_a, dec_rs_b, ex_src_a, ex_src_b, em_dst, mw_dst} = '0;
    {ex_val_a, ex_val_b, ex_imm, em_res, mw_res} = '0;
    {ex_use_imm, em_we, mw_we} = '0;
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 32; i++) model[i] = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: every register reads zero after reset
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); dec_rs_a = 5'(i); dec_rs_b = 5'(31 - i); #2;
      chk("R9 reset read_a", dec_val_a, 0);
      chk("R9 reset read_b", dec_val_b, 0);
    end
    // R4: three chained writers of register 1
    @(negedge clk); idle();
    ex_src_a = 1; ex_src_b = 1; em_dst = 1; em_we = 1; em_res = 32'hAAAA0001;
    mw_dst = 1; mw_we = 1; mw_res = 32'h5555_0002; ex_val_a = 32'h1234;
    check_all();
    chk("R4 newest wins", op_a, 32'hAAAA0001);
    // R5: write enabled to register 0 is never forwarded, and never stored (R7)
    @(negedge clk); idle();
    em_we = 1; mw_we = 1; em_res = 32'hDEAD; mw_res = 32'hBEEF;
    ex_val_a = 32'h77; ex_val_b = 32'h88; dec_rs_a = 0;
    check_all();
    chk("R5 zero src op_a", op_a, 32'h77);
    @(negedge clk); idle(); check_all();
    chk("R7 reg0 stays zero", dec_val_a, 0);
    // R6: store with immediate still gets forwarded data
    @(negedge clk); idle();
    ex_src_b = 7; em_dst = 7; em_we = 1; em_res = 32'hCAFE0007;
    ex_use_imm = 1; ex_imm = 32'hFFFF_FFF0; ex_val_b = 32'h1;
    check_all();
    chk("R6 store fwd", store_data, 32'hCAFE0007);
    chk("R6 imm op", op_b, 32'hFFFF_FFF0);
    // R8 then R7: same-cycle bypass then stored value
    @(negedge clk); idle();
    mw_we = 1; mw_dst = 9; mw_res = 32'h0909_0909; dec_rs_a = 9; dec_rs_b = 9;
    check_all();
    chk("R8 bypass", dec_val_a, 32'h0909_0909);
    @(negedge clk); idle(); dec_rs_a = 9; check_all();
    chk("R7 written", dec_val_a, 32'h0909_0909);
    // random traffic with narrow register range
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      dec_rs_a = 5'($urandom_range(0, 4)); dec_rs_b = 5'($urandom_range(0, 4));
      ex_src_a = 5'($urandom_range(0, 3)); ex_src_b = 5'($urandom_range(0, 3));
      em_dst = 5'($urandom_range(0, 3)); mw_dst = 5'($urandom_range(0, 4));
      em_we = 1'($urandom); mw_we = 1'($urandom); ex_use_imm = 1'($urandom);
      ex_val_a = $urandom; ex_val_b = $urandom; ex_imm = $urandom;
      em_res = $urandom; mw_res = $urandom;
      check_all();
    end
    @(negedge clk); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule